// File: doc/BRIEF.md
# FG Speed Discriminator with Lock Detect

This block closes the digital half of a motor speed servo. It times the squared tachometer (FG) pulse train against a reference clock. The reference clock is first divided by a power-of-two prescaler, and the interval between FG rising edges is counted in the resulting ticks. The nominal interval is `TARGET` ticks; with the defaults (divide by 16, 512 ticks) the servo FG frequency is the reference frequency divided by 8192.

Three results come out of the timing. A frequency decision (`accel`) is taken once for every two measured FG intervals: high asks the drive to speed up, low asks it to slow down. A phase error is produced on every interval. `ph_up` is high while the current FG edge is overdue. `ph_dn` is a pulse after an early edge, and its width is proportional to how early the edge came. An active-low flag (`lock_n`) reports whether the most recent interval lies within ±6.25 % of the target.

While `run` is low, every counter is cleared and the outputs rest at decelerate, unlocked, with no phase pulses. An external integrator combines the frequency and phase signals into the drive command.

Top module: `fg_speed_discriminator`

## Requirements
- R1: While `run` is low, one cycle later and for as long as it stays low: `accel`=0, `lock_n`=1, `ph_up`=0, `ph_dn`=0. FG activity is ignored in this state.
- R2: An interval is measured as the number of prescaler ticks between two FG rising edges, with one tick every 2^`PRE_LOG2` reference cycles. An interval of exactly N·2^`PRE_LOG2` cycles reads as N.
- R3: After each measured interval m, `lock_n` becomes 0 when TARGET−TARGET/16 ≤ m ≤ TARGET+TARGET/16 (inclusive), and 1 otherwise.
- R4: Measured intervals are taken in pairs. After the second interval of a pair, `accel` becomes 1 if the sum of the pair exceeds 2·TARGET, and 0 if the sum is equal or smaller. Between decisions it holds.
- R5: Once a first FG edge has been seen, `ph_up` is high while the ticks counted since the last edge exceed TARGET, and it drops after the next edge.
- R6: After an interval m < TARGET, `ph_dn` is high for TARGET−m ticks. After an interval m ≥ TARGET, it stays low.
- R7: The first FG edge after `run` rises only starts timing. It produces no lock, no frequency decision and no phase pulse.
- R8: The interval count saturates at 2^CNT_W−1 (CNT_W = clog2(TARGET)+2). While it is saturated, `accel` is forced to 1, so a stalled motor reads as too slow.
- R9: `ph_up` and `ph_dn` are never high together.
- R10: `lock_n` rises as soon as the running count exceeds TARGET+TARGET/16, without waiting for the overdue edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| run | input | 1 | 1 = servo active, 0 = stop mode |
| fg_in | input | 1 | Squared tachometer signal, asynchronous |
| accel | output | 1 | Frequency decision: 1 accelerate, 0 decelerate |
| ph_up | output | 1 | Phase error: FG edge overdue |
| ph_dn | output | 1 | Phase error: FG edge early, width-coded |
| lock_n | output | 1 | 0 when speed is within ±6.25 % of target |

## Verification
The hardest states to reach from the ports are the exact lock-window boundaries and the stall saturation. A boundary check only means something if the measured tick count is known exactly, regardless of where the prescaler phase sits. The bench therefore spaces every FG rising edge at a whole multiple of the prescale period, which makes the count deterministic; it then drives intervals of 59, 60, 68 and 69 ticks and equal-sum pairs. Stall is reached by building the block with a small target and holding FG still past the saturation span after `run` rises. The bench checks `accel` just before and just after the expected saturation cycle. Random intervals from a fixed seed then exercise the pairing, the phase pulse widths and the mid-interval unlock.

// File: rtl/fgsd_pkg.sv
package fgsd_pkg;

   // true when val lies within ctr +/- tol, bounds included
   function automatic logic in_band(input int val, input int ctr, input int tol);
      return (val >= ctr - tol) && (val <= ctr + tol);
   endfunction

endpackage

// File: rtl/fgsd_tick_gen.sv
module fgsd_tick_gen #(
   parameter int PRE_LOG2 = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (PRE_LOG2 == 0) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) tick <= 1'b0;
            else        tick <= run;
         end
      end else begin : g_div
         logic [PRE_LOG2-1:0] div_q;

         always_ff @(posedge clk) begin
            if (!rst_n || !run) div_q <= '0;
            else                div_q <= div_q + 1'b1;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) tick <= 1'b0;
            else        tick <= run && (&div_q);
         end

         AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);                                           // R2
      end
   endgenerate

endmodule

// File: rtl/fgsd_fg_edge.sv
module fgsd_fg_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic fg_in,
   output logic rise
);

   logic s1_q, s2_q, s3_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q <= 1'b0;
         s2_q <= 1'b0;
         s3_q <= 1'b0;
      end else begin
         s1_q <= fg_in;
         s2_q <= s1_q;
         s3_q <= s2_q;
      end
   end

   assign rise = s2_q & ~s3_q;

endmodule

// File: rtl/fgsd_period_meter.sv
module fgsd_period_meter #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             rise,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] meas,
   output logic             meas_vld,
   output logic             armed,
   output logic             sat
);

   localparam logic [CNT_W-1:0] MAXV = '1;

   logic [CNT_W-1:0] cnt_inc;

   assign sat     = (cnt == MAXV);
   assign cnt_inc = (tick && !sat) ? cnt + 1'b1 : cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt      <= '0;
         meas     <= '0;
         meas_vld <= 1'b0;
         armed    <= 1'b0;
      end else begin
         meas_vld <= rise && armed;
         if (rise) begin
            meas  <= cnt_inc;
            cnt   <= '0;
            armed <= 1'b1;
         end else begin
            cnt <= cnt_inc;
         end
      end
   end

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (run && rise) |=> (cnt == '0));                                  // R2
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (run && sat && !rise) |=> sat);                                  // R8
   AST_FIRST_EDGE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (run && rise && !armed) |=> (!meas_vld && armed));               // R7

endmodule

// File: rtl/fgsd_error_out.sv
module fgsd_error_out #(
   parameter int CNT_W  = 11,
   parameter int TARGET = 512,
   parameter int BAND   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] meas,
   input  logic             meas_vld,
   input  logic             armed,
   input  logic             sat,
   output logic             accel,
   output logic             ph_up,
   output logic             ph_dn,
   output logic             lock_n
);

   localparam logic [CNT_W-1:0] TGT_V  = CNT_W'(TARGET);
   localparam logic [CNT_W-1:0] HI_V   = CNT_W'(TARGET + BAND);
   localparam logic [CNT_W:0]   TWO_T  = (CNT_W + 1)'(2 * TARGET);

   logic             half_q;
   logic [CNT_W-1:0] first_q;
   logic [CNT_W-1:0] rem_q;
   logic [CNT_W:0]   pair_sum;
   logic             meas_ok;

   assign pair_sum = {1'b0, first_q} + {1'b0, meas};
   assign meas_ok  = fgsd_pkg::in_band(int'(meas), TARGET, BAND);
   assign ph_dn    = (rem_q != '0);

   // frequency decision over interval pairs, stall override
   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         half_q  <= 1'b0;
         first_q <= '0;
         accel   <= 1'b0;
      end else if (meas_vld) begin
         if (!half_q) begin
            first_q <= meas;
            half_q  <= 1'b1;
         end else begin
            half_q <= 1'b0;
            accel  <= (pair_sum > TWO_T);
         end
      end else if (sat) begin
         accel <= 1'b1;
      end
   end

   // lock window
   always_ff @(posedge clk) begin
      if (!rst_n || !run)     lock_n <= 1'b1;
      else if (meas_vld)      lock_n <= !meas_ok;
      else if (cnt > HI_V)    lock_n <= 1'b1;
   end

   // phase error: late while overdue, early as a width-coded pulse
   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         ph_up <= 1'b0;
         rem_q <= '0;
      end else begin
         ph_up <= armed && (cnt > TGT_V);
         if (meas_vld)                rem_q <= (meas < TGT_V) ? TGT_V - meas : '0;
         else if (tick && ph_dn)      rem_q <= rem_q - 1'b1;
      end
   end

   AST_PH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ph_up && ph_dn));                                              // R9
   AST_LOCK_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      (run && meas_vld && meas_ok) |=> !lock_n);                       // R3
   AST_ACCEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !meas_vld && !sat) |=> $stable(accel));                  // R4
   AST_STALL_ACCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (run && sat) |=> accel);                                         // R8
   AST_DN_AFTER_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (run && meas_vld && (meas < TGT_V)) |=> ph_dn);                  // R6

endmodule

// File: rtl/fg_speed_discriminator.sv
module fg_speed_discriminator #(
   parameter int PRE_LOG2 = 4,
   parameter int TARGET   = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fg_in,
   output logic accel,
   output logic ph_up,
   output logic ph_dn,
   output logic lock_n
);

   localparam int BAND  = TARGET / 16;
   localparam int CNT_W = $clog2(TARGET) + 2;

   generate
      if (TARGET < 16 || (TARGET % 16) != 0) begin : g_bad_target
         $error("TARGET must be a multiple of 16 and at least 16");
      end
      if (PRE_LOG2 < 0 || PRE_LOG2 > 12) begin : g_bad_prescale
         $error("PRE_LOG2 must lie in 0..12");
      end
   endgenerate

   logic             tick;
   logic             rise;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] meas;
   logic             meas_vld;
   logic             armed;
   logic             sat;

   fgsd_tick_gen #(.PRE_LOG2(PRE_LOG2)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   fgsd_fg_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .fg_in (fg_in),
      .rise  (rise)
   );

   fgsd_period_meter #(.CNT_W(CNT_W)) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (tick),
      .rise     (rise),
      .cnt      (cnt),
      .meas     (meas),
      .meas_vld (meas_vld),
      .armed    (armed),
      .sat      (sat)
   );

   fgsd_error_out #(.CNT_W(CNT_W), .TARGET(TARGET), .BAND(BAND)) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (tick),
      .cnt      (cnt),
      .meas     (meas),
      .meas_vld (meas_vld),
      .armed    (armed),
      .sat      (sat),
      .accel    (accel),
      .ph_up    (ph_up),
      .ph_dn    (ph_dn),
      .lock_n   (lock_n)
   );

   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!accel && lock_n && !ph_up && !ph_dn));                // R1

endmodule

// File: tb/tb_fg_speed_discriminator.sv
module tb_fg_speed_discriminator;

   localparam int PL   = 2;
   localparam int P    = 4;
   localparam int T    = 64;
   localparam int TOL  = T / 16;
   localparam int MAXC = 255;
   localparam int R10C = (T + TOL + 1) * P + 6;

   logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, fg_in = 1'b0;
   logic accel, ph_up, ph_dn, lock_n;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model state
   bit armed_m, half_m;
   int first_m, last_n, dn_m;
   bit exp_accel, exp_lock_n;
   int up_acc, dn_acc, both_acc;

   fg_speed_discriminator #(.PRE_LOG2(PL), .TARGET(T)) dut (
      .clk(clk), .rst_n(rst_n), .run(run), .fg_in(fg_in),
      .accel(accel), .ph_up(ph_up), .ph_dn(ph_dn), .lock_n(lock_n)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
      end
   endtask

   task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk(accel == 1'b0,  tag, accel, 0);
      chk(lock_n == 1'b1, tag, lock_n, 1);
      chk(ph_up == 1'b0,  tag, ph_up, 0);
      chk(ph_dn == 1'b0,  tag, ph_dn, 0);
   endtask

   task automatic start_run();
      @(negedge clk);
      run = 1'b1;
      armed_m = 0; half_m = 0; first_m = 0; last_n = 0; dn_m = -1;
      exp_accel = 0; exp_lock_n = 1;
      up_acc = 0; dn_acc = 0; both_acc = 0;
   endtask

   // one FG interval of n ticks; checks the effect of the interval that ends at its rising edge
   task automatic pulse(input int n);
      int m;
      bit per_ok;
      int up_lo, up_hi;
      per_ok = 0; up_lo = 0; up_hi = 0;
      for (int c = 0; c < n * P; c++) begin
         @(negedge clk);
         if (ph_up) up_acc++;
         if (ph_dn) dn_acc++;
         if (ph_up && ph_dn) both_acc++;
         if (c == 0) begin
            if (dn_m < 0)
               chk_rng("R6 R7 no ph_dn without a measured interval", dn_acc, 0, 0);
            else if (dn_m >= T)
               chk_rng("R6 ph_dn idle after on-time or late interval", dn_acc, 0, 5);
            else if ((T - dn_m) * P + 8 < last_n * P)
               chk_rng("R6 ph_dn width after early interval", dn_acc, (T - dn_m - 1) * P - 1, (T - dn_m) * P + 5);
            dn_acc = 0;
            per_ok = armed_m;
            if (per_ok) begin
               m = (last_n > MAXC) ? MAXC : last_n;
               exp_lock_n = !(m >= T - TOL && m <= T + TOL);
               if (!half_m) begin first_m = m; half_m = 1; end
               else begin half_m = 0; exp_accel = (first_m + m) > 2 * T; end
               if (last_n > T) begin
                  up_lo = (last_n - T - 1) * P - 2;
                  up_hi = (last_n - T) * P + 2;
               end
               dn_m = m;
            end else begin
               dn_m = -1;
            end
            fg_in = 1'b1;
         end
         if (c == 8) begin
            if (per_ok) chk(lock_n == exp_lock_n, "R2 R3 lock flag after interval", lock_n, exp_lock_n);
            else        chk(lock_n == exp_lock_n, "R7 first edge gives no lock", lock_n, exp_lock_n);
            chk(accel == exp_accel, "R4 R8 frequency decision", accel, exp_accel);
            chk_rng("R5 ph_up width of overdue interval", up_acc, up_lo, up_hi);
            chk(both_acc == 0, "R9 ph_up and ph_dn overlap cycles", both_acc, 0);
            up_acc = 0;
            both_acc = 0;
         end
         if (c == R10C && n * P > R10C + 2)
            chk(lock_n == 1'b1, "R10 unlock while edge overdue", lock_n, 1);
         if (c == (n * P) / 2 - 1) fg_in = 1'b0;
      end
      armed_m = 1;
      last_n = n;
   endtask

   task automatic stop_run();
      @(negedge clk);
      run = 1'b0;
      repeat (2) @(negedge clk);
      chk_idle("R1 outputs idle after stop");
      for (int k = 0; k < 3; k++) begin
         fg_in = 1'b1;
         repeat (20) @(negedge clk);
         fg_in = 1'b0;
         repeat (20) @(negedge clk);
         chk_idle("R1 FG ignored while stopped");
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int dir_list[18] = '{64, 64, 60, 68, 59, 69, 64, 65, 63, 65, 80, 40, 64, 64, 100, 64, 30, 64};
      int r;
      r = $urandom(32'd7731);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_idle("R1 reset state");
      stop_run();

      // directed boundaries and equal-sum pairs
      start_run();
      foreach (dir_list[i]) pulse(dir_list[i]);

      // constrained random intervals
      for (int i = 0; i < 110; i++) pulse(int'($urandom_range(110, 30)));
      pulse(64);
      stop_run();

      // stalled motor after start
      start_run();
      repeat (1000) @(negedge clk);
      chk(accel == 1'b0, "R8 accel before saturation", accel, 0);
      repeat (40) @(negedge clk);
      chk(accel == 1'b1, "R8 accel forced at saturation", accel, 1);
      chk(lock_n == 1'b1, "R8 stall unlocked", lock_n, 1);
      exp_accel = 1;
      pulse(64);
      pulse(64);
      pulse(64);
      pulse(66);
      pulse(62);
      pulse(64);
      stop_run();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule